// File: doc/BRIEF.md
# Debug Comms Mailbox

This block passes 32-bit words in both directions between an external debugger and software on the processor. The debugger reaches it through a register port clocked by the test clock: a register address, separate read and write strobes, and a data bus. Software reaches it through a coprocessor-style port clocked by the core clock. That port has a select bit that picks either the data register or the control register, plus read and write strobes.

Each direction has its own data register and its own pending flag.

- **Debugger to CPU (inbound):** a debugger write fills the inbound word. A CPU data read consumes it.
- **CPU to debugger (outbound):** a CPU write fills the outbound word. A debugger data read consumes it.

The control register carries four things:

- a fixed version code in its top nibble;
- the inbound flag at bit 0;
- the outbound flag at bit 1;
- a sticky overrun bit at bit 2, which reports on the writes made by the side that is reading the register.

Flags cross between the two clock domains as toggle events through two-flop synchronizers. Because of this, a debugger can stream words at one per scan without polling, or it can poll a flag before each word.

Top module: `dcc_mailbox`

## Requirements
- R1: After reset, a control read on either port returns only the version code: flags at bits 0 and 1 are 0 and overrun at bit 2 is 0.
- R2: Bits 31:28 of the control word hold the VERSION parameter on both ports; all bits other than 31:28 and 2:0 read 0.
- R3: A debugger write to the data address stores the word and sets bit 0. Bit 0 is set in the debugger's control view on the next test clock, and in the CPU's view within 3 core clocks. The CPU data read then returns the word.
- R4: A CPU data read while bit 0 is set consumes the word. Bit 0 clears in the CPU view on the next core clock, and in the debugger view within 3 test clocks.
- R5: A CPU data write stores the word and sets bit 1. Bit 1 is set in the CPU view on the next core clock, and in the debugger view within 3 test clocks. The debugger data read then returns the word.
- R6: A debugger data read while bit 1 is set clears bit 1 in both views. A debugger data read while bit 1 is clear changes no flag.
- R7: A debugger control read has no side effect: flags and data stay unchanged.
- R8: A write into a direction whose flag is already set, as seen by the writer, overwrites the word and sets that writer's sticky overrun bit 2. Only reset clears the overrun bit.
- R9: CPU writes with the control selected are ignored: no flag, overrun or data changes.
- R10: Debugger words written one per 38 test clocks, without polling, all reach a CPU that reads each word on its flag. They arrive in order and with no overrun.
- R11: Debugger reads of an address that is neither data nor control return 0, and writes to such an address change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tckClk | input | 1 | Debugger-side test clock |
| tckRstN | input | 1 | Active-low reset, test clock domain |
| dbgAddr | input | ADDR_W | Debugger register address |
| dbgRdEn | input | 1 | Debugger read strobe |
| dbgWrEn | input | 1 | Debugger write strobe |
| dbgWrData | input | DATA_W | Debugger write data |
| dbgRdData | output | DATA_W | Debugger read data (combinational on address) |
| coreClk | input | 1 | Processor clock |
| coreRstN | input | 1 | Active-low reset, core domain |
| cpuRegSel | input | 1 | 1 selects data, 0 selects control |
| cpuRdEn | input | 1 | CPU read strobe |
| cpuWrEn | input | 1 | CPU write strobe |
| cpuWrData | input | DATA_W | CPU write data |
| cpuRdData | output | DATA_W | CPU read data (combinational on select) |

## Verification
The bench builds the block with VERSION set to 4'hA, so the top nibble is told apart from a zero default. The control address is 4 and the data address is 5, with 32-bit data and two synchronizer stages. The test clock runs five times slower than the core clock and is offset in phase. This brings the 3-cycle crossing bounds within reach in both directions. It also makes the 38-cycle streaming window long enough for a polling CPU to drain each word before the next one lands.

// File: rtl/dcc_pkg.sv
package dcc_pkg;
  localparam int RX_FLAG_BIT = 0;
  localparam int TX_FLAG_BIT = 1;
  localparam int OVR_BIT     = 2;

  typedef struct packed {
    logic rxLoad;      // debugger word lands in inbound register
    logic txLoad;      // cpu word lands in outbound register
    logic dbgSelData;  // debugger address hits data
    logic dbgSelCtrl;  // debugger address hits control
    logic cpuSelData;  // cpu port selects data
  } dccStrobes_t;
endpackage

// File: rtl/dcc_sync.sv
module dcc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] pipe;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) pipe <= '0;
        else       pipe <= d;
    end else begin : g_many
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) pipe <= '0;
        else       pipe <= {pipe[STAGES-2:0], d};
    end
  endgenerate

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/dcc_ctrl.sv
module dcc_ctrl
  import dcc_pkg::*;
#(
  parameter int              DATA_W      = 32,
  parameter int              ADDR_W      = 5,
  parameter logic [3:0]      VERSION     = 4'd6,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 5'd4,
  parameter logic [ADDR_W-1:0] DATA_ADDR = 5'd5,
  parameter int              SYNC_STAGES = 2
) (
  input  logic              tckClk,
  input  logic              tckRstN,
  input  logic [ADDR_W-1:0] dbgAddr,
  input  logic              dbgRdEn,
  input  logic              dbgWrEn,
  input  logic              coreClk,
  input  logic              coreRstN,
  input  logic              cpuRegSel,
  input  logic              cpuRdEn,
  input  logic              cpuWrEn,
  output dccStrobes_t       strobes,
  output logic [DATA_W-1:0] dbgStatus,
  output logic [DATA_W-1:0] cpuStatus
);
  localparam int VER_LSB = DATA_W - 4;

  logic rxPut, rxTake, txPut, txTake;
  logic rxPutSync, rxTakeSync, txPutSync, txTakeSync;
  logic rxFullTck, txFullTck, rxFullCore, txFullCore;
  logic rxOvr, txOvr;
  logic dbgHitData, dbgHitCtrl, dbgTake, cpuTake;

  assign dbgHitData = (dbgAddr == DATA_ADDR);
  assign dbgHitCtrl = (dbgAddr == CTRL_ADDR);

  // Toggle crossings: each event flips its toggle; a flag is the xor of
  // the local toggle and the synchronized peer toggle.
  dcc_sync #(.STAGES(SYNC_STAGES)) uRxPutSync  (.clk(coreClk), .rstN(coreRstN), .d(rxPut),  .q(rxPutSync));
  dcc_sync #(.STAGES(SYNC_STAGES)) uTxTakeSync (.clk(coreClk), .rstN(coreRstN), .d(txTake), .q(txTakeSync));
  dcc_sync #(.STAGES(SYNC_STAGES)) uRxTakeSync (.clk(tckClk),  .rstN(tckRstN),  .d(rxTake), .q(rxTakeSync));
  dcc_sync #(.STAGES(SYNC_STAGES)) uTxPutSync  (.clk(tckClk),  .rstN(tckRstN),  .d(txPut),  .q(txPutSync));

  assign rxFullTck  = rxPut ^ rxTakeSync;
  assign txFullTck  = txPutSync ^ txTake;
  assign rxFullCore = rxPutSync ^ rxTake;
  assign txFullCore = txPut ^ txTakeSync;

  assign strobes.rxLoad     = dbgWrEn && dbgHitData;
  assign strobes.txLoad     = cpuWrEn && cpuRegSel;
  assign strobes.dbgSelData = dbgHitData;
  assign strobes.dbgSelCtrl = dbgHitCtrl;
  assign strobes.cpuSelData = cpuRegSel;

  assign dbgTake = dbgRdEn && dbgHitData && txFullTck;
  assign cpuTake = cpuRdEn && cpuRegSel && rxFullCore;

  // test clock domain
  always_ff @(posedge tckClk or negedge tckRstN) begin
    if (!tckRstN) begin
      rxPut  <= 1'b0;
      txTake <= 1'b0;
      rxOvr  <= 1'b0;
    end else begin
      if (strobes.rxLoad) begin
        if (rxFullTck) rxOvr <= 1'b1;
        else           rxPut <= ~rxPut;
      end
      if (dbgTake) txTake <= ~txTake;
    end
  end

  // core clock domain
  always_ff @(posedge coreClk or negedge coreRstN) begin
    if (!coreRstN) begin
      txPut  <= 1'b0;
      rxTake <= 1'b0;
      txOvr  <= 1'b0;
    end else begin
      if (strobes.txLoad) begin
        if (txFullCore) txOvr <= 1'b1;
        else            txPut <= ~txPut;
      end
      if (cpuTake) rxTake <= ~rxTake;
    end
  end

  always_comb begin
    dbgStatus                    = '0;
    dbgStatus[DATA_W-1:VER_LSB]  = VERSION;
    dbgStatus[RX_FLAG_BIT]       = rxFullTck;
    dbgStatus[TX_FLAG_BIT]       = txFullTck;
    dbgStatus[OVR_BIT]           = rxOvr;
    cpuStatus                    = '0;
    cpuStatus[DATA_W-1:VER_LSB]  = VERSION;
    cpuStatus[RX_FLAG_BIT]       = rxFullCore;
    cpuStatus[TX_FLAG_BIT]       = txFullCore;
    cpuStatus[OVR_BIT]           = txOvr;
  end

  AST_RX_LOAD_FULL: assert property (@(posedge tckClk) disable iff (!tckRstN)
    (strobes.rxLoad && !rxFullTck) |=> rxFullTck); // R3
  AST_TX_TAKE_EMPTY: assert property (@(posedge tckClk) disable iff (!tckRstN)
    dbgTake |=> !txFullTck); // R6
  AST_CTRL_READ_QUIET: assert property (@(posedge tckClk) disable iff (!tckRstN)
    (dbgRdEn && dbgHitCtrl && !dbgWrEn) |=> ($stable(txTake) && $stable(rxPut))); // R7
  AST_RX_OVR_STICKY: assert property (@(posedge tckClk) disable iff (!tckRstN)
    rxOvr |=> rxOvr); // R8
  AST_CPU_TAKE: assert property (@(posedge coreClk) disable iff (!coreRstN)
    cpuTake |=> !rxFullCore); // R4
  AST_TX_LOAD_FULL: assert property (@(posedge coreClk) disable iff (!coreRstN)
    (strobes.txLoad && !txFullCore) |=> txFullCore); // R5
  AST_TX_OVR_STICKY: assert property (@(posedge coreClk) disable iff (!coreRstN)
    txOvr |=> txOvr); // R8
  AST_CPU_CTRL_WRITE: assert property (@(posedge coreClk) disable iff (!coreRstN)
    (cpuWrEn && !cpuRegSel) |=> ($stable(txPut) && $stable(txOvr))); // R9
endmodule

// File: rtl/dcc_data.sv
module dcc_data
  import dcc_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              tckClk,
  input  logic              tckRstN,
  input  logic              coreClk,
  input  logic              coreRstN,
  input  dccStrobes_t       strobes,
  input  logic [DATA_W-1:0] dbgWrData,
  input  logic [DATA_W-1:0] cpuWrData,
  input  logic [DATA_W-1:0] dbgStatus,
  input  logic [DATA_W-1:0] cpuStatus,
  output logic [DATA_W-1:0] dbgRdData,
  output logic [DATA_W-1:0] cpuRdData
);
  logic [DATA_W-1:0] rxWord, txWord;

  always_ff @(posedge tckClk or negedge tckRstN)
    if (!tckRstN)           rxWord <= '0;
    else if (strobes.rxLoad) rxWord <= dbgWrData;

  always_ff @(posedge coreClk or negedge coreRstN)
    if (!coreRstN)          txWord <= '0;
    else if (strobes.txLoad) txWord <= cpuWrData;

  always_comb begin
    if (strobes.dbgSelData)      dbgRdData = txWord;
    else if (strobes.dbgSelCtrl) dbgRdData = dbgStatus;
    else                         dbgRdData = '0;
    cpuRdData = strobes.cpuSelData ? rxWord : cpuStatus;
  end

  AST_UNMAPPED_ZERO: assert property (@(posedge tckClk) disable iff (!tckRstN)
    (!strobes.dbgSelData && !strobes.dbgSelCtrl) |-> (dbgRdData == '0)); // R11
endmodule

// File: rtl/dcc_mailbox.sv
module dcc_mailbox
  import dcc_pkg::*;
#(
  parameter int              DATA_W      = 32,
  parameter int              ADDR_W      = 5,
  parameter logic [3:0]      VERSION     = 4'd6,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 5'd4,
  parameter logic [ADDR_W-1:0] DATA_ADDR = 5'd5,
  parameter int              SYNC_STAGES = 2
) (
  input  logic              tckClk,
  input  logic              tckRstN,
  input  logic [ADDR_W-1:0] dbgAddr,
  input  logic              dbgRdEn,
  input  logic              dbgWrEn,
  input  logic [DATA_W-1:0] dbgWrData,
  output logic [DATA_W-1:0] dbgRdData,
  input  logic              coreClk,
  input  logic              coreRstN,
  input  logic              cpuRegSel,
  input  logic              cpuRdEn,
  input  logic              cpuWrEn,
  input  logic [DATA_W-1:0] cpuWrData,
  output logic [DATA_W-1:0] cpuRdData
);
  dccStrobes_t       strobes;
  logic [DATA_W-1:0] dbgStatus, cpuStatus;

  dcc_ctrl #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .VERSION(VERSION),
    .CTRL_ADDR(CTRL_ADDR), .DATA_ADDR(DATA_ADDR), .SYNC_STAGES(SYNC_STAGES)
  ) uCtrl (
    .tckClk(tckClk), .tckRstN(tckRstN), .dbgAddr(dbgAddr),
    .dbgRdEn(dbgRdEn), .dbgWrEn(dbgWrEn),
    .coreClk(coreClk), .coreRstN(coreRstN), .cpuRegSel(cpuRegSel),
    .cpuRdEn(cpuRdEn), .cpuWrEn(cpuWrEn),
    .strobes(strobes), .dbgStatus(dbgStatus), .cpuStatus(cpuStatus)
  );

  dcc_data #(.DATA_W(DATA_W)) uData (
    .tckClk(tckClk), .tckRstN(tckRstN), .coreClk(coreClk), .coreRstN(coreRstN),
    .strobes(strobes), .dbgWrData(dbgWrData), .cpuWrData(cpuWrData),
    .dbgStatus(dbgStatus), .cpuStatus(cpuStatus),
    .dbgRdData(dbgRdData), .cpuRdData(cpuRdData)
  );
endmodule

// File: tb/tb_dcc_mailbox.sv
`timescale 1ns/1ps
module tb_dcc_mailbox;
  localparam logic [4:0] CA = 5'd4;
  localparam logic [4:0] DA = 5'd5;
  localparam logic [31:0] VW = 32'hA000_0000;

  logic tckClk = 0, coreClk = 0, tckRstN = 0, coreRstN = 0;
  logic [4:0] dbgAddr = '0;
  logic dbgRdEn = 0, dbgWrEn = 0, cpuRegSel = 0, cpuRdEn = 0, cpuWrEn = 0;
  logic [31:0] dbgWrData = '0, cpuWrData = '0, dbgRdData, cpuRdData;
  int total = 0, bad = 0;

  always #4 coreClk = ~coreClk;
  initial begin #3; forever #20 tckClk = ~tckClk; end

  dcc_mailbox #(.DATA_W(32), .ADDR_W(5), .VERSION(4'hA), .CTRL_ADDR(CA),
                .DATA_ADDR(DA), .SYNC_STAGES(2)) dut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic waitTck(input int n);  repeat (n) @(negedge tckClk);  endtask
  task automatic waitCore(input int n); repeat (n) @(negedge coreClk); endtask

  task automatic dbgWrite(input logic [4:0] a, input logic [31:0] d);
    @(negedge tckClk); dbgAddr = a; dbgWrData = d; dbgWrEn = 1;
    @(negedge tckClk); dbgWrEn = 0;
  endtask
  task automatic dbgRead(input logic [4:0] a, output logic [31:0] d);
    @(negedge tckClk); dbgAddr = a; dbgRdEn = 1; #1 d = dbgRdData;
    @(negedge tckClk); dbgRdEn = 0;
  endtask
  task automatic cpuWrite(input logic sel, input logic [31:0] d);
    @(negedge coreClk); cpuRegSel = sel; cpuWrData = d; cpuWrEn = 1;
    @(negedge coreClk); cpuWrEn = 0;
  endtask
  task automatic cpuRead(input logic sel, output logic [31:0] d);
    @(negedge coreClk); cpuRegSel = sel; cpuRdEn = 1; #1 d = cpuRdData;
    @(negedge coreClk); cpuRdEn = 0;
  endtask

  task automatic doReset();
    tckRstN = 0; coreRstN = 0;
    waitTck(3);
    tckRstN = 1; coreRstN = 1;
    waitTck(2);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    dbgRead(CA, v); chk("R1 dbg ctrl after reset", v, VW);
    cpuRead(0, v);  chk("R2 cpu ctrl version", v, VW);
  endtask

  task automatic t_dbgToCpu();
    logic [31:0] v;
    dbgWrite(DA, 32'h1234_5678);
    dbgRead(CA, v); chk("R3 dbg view flag set", v, VW | 1);
    waitCore(3);
    cpuRead(0, v);  chk("R3 cpu view flag within 3", v, VW | 1);
    cpuRead(1, v);  chk("R3 cpu data word", v, 32'h1234_5678);
    cpuRead(0, v);  chk("R4 cpu flag cleared", v, VW);
    waitTck(3);
    dbgRead(CA, v); chk("R4 dbg flag cleared", v, VW);
  endtask

  task automatic t_cpuToDbg();
    logic [31:0] v;
    cpuWrite(1, 32'hCAFE_F00D);
    cpuRead(0, v);  chk("R5 cpu view tx flag", v, VW | 2);
    waitTck(3);
    dbgRead(CA, v); chk("R5 dbg view tx flag", v, VW | 2);
    dbgRead(CA, v); chk("R7 ctrl read quiet", v, VW | 2);
    dbgRead(DA, v); chk("R5 dbg data word", v, 32'hCAFE_F00D);
    dbgRead(CA, v); chk("R6 dbg tx flag cleared", v, VW);
    waitCore(3);
    cpuRead(0, v);  chk("R6 cpu tx flag cleared", v, VW);
    dbgRead(DA, v); chk("R6 empty read keeps word", v, 32'hCAFE_F00D);
    dbgRead(CA, v); chk("R6 empty read no flag change", v, VW);
  endtask

  task automatic t_overrun();
    logic [31:0] v;
    dbgWrite(DA, 32'h1111_1111);
    dbgWrite(DA, 32'h2222_2222);
    dbgRead(CA, v); chk("R8 dbg overrun set", v, VW | 5);
    waitCore(3);
    cpuRead(1, v);  chk("R8 overwritten word", v, 32'h2222_2222);
    cpuRead(0, v);  chk("R8 cpu side no overrun", v, VW);
    waitTck(3);
    dbgRead(CA, v); chk("R8 dbg overrun sticky", v, VW | 4);
    cpuWrite(1, 32'h3333_3333);
    cpuWrite(1, 32'h4444_4444);
    cpuRead(0, v);  chk("R8 cpu overrun set", v, VW | 6);
    waitTck(3);
    dbgRead(DA, v); chk("R8 cpu overwritten word", v, 32'h4444_4444);
    waitCore(3);
    cpuRead(0, v);  chk("R8 cpu overrun sticky", v, VW | 4);
    doReset();
    dbgRead(CA, v); chk("R8 reset clears dbg overrun", v, VW);
    cpuRead(0, v);  chk("R8 reset clears cpu overrun", v, VW);
  endtask

  task automatic t_cpuCtrlWrite();
    logic [31:0] v;
    cpuWrite(0, 32'hFFFF_FFFF);
    cpuRead(0, v);  chk("R9 cpu ctrl unchanged", v, VW);
    waitTck(3);
    dbgRead(CA, v); chk("R9 dbg ctrl unchanged", v, VW);
    dbgRead(DA, v); chk("R9 no data loaded", v, 32'h0);
  endtask

  task automatic t_unmapped();
    logic [31:0] v;
    dbgRead(5'd0, v);  chk("R11 unmapped read zero", v, 32'h0);
    dbgWrite(5'd9, 32'hDEAD_BEEF);
    dbgRead(CA, v);    chk("R11 unmapped write no flag", v, VW);
    waitCore(3);
    cpuRead(1, v);     chk("R11 unmapped write no data", v, 32'h0);
  endtask

  task automatic t_stream();
    logic [31:0] v;
    fork
      begin
        for (int k = 0; k < 6; k++) begin
          dbgWrite(DA, 32'h5000_0000 + k);
          waitTck(36);
        end
      end
      begin
        for (int k = 0; k < 6; k++) begin
          logic [31:0] st, d;
          do cpuRead(0, st); while (!st[0]);
          cpuRead(1, d);
          chk("R10 streamed word", d, 32'h5000_0000 + k);
        end
      end
    join
    waitTck(3);
    dbgRead(CA, v); chk("R10 no overrun after stream", v, VW);
  endtask

  initial begin
    #2_000_000;
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    doReset();
    t_reset();
    t_dbgToCpu();
    t_cpuToDbg();
    t_overrun();
    t_cpuCtrlWrite();
    t_unmapped();
    t_stream();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule